// File: doc/BRIEF.md
# Polynomial-Basis Field Multiplier over GF(2^k)

This block multiplies two elements of the binary extension field GF(2^k) held in polynomial basis. Bit i of an operand is the coefficient of alpha^i, where alpha is a root of the field polynomial P(x) of degree k. The result uses the same encoding. The block is purely combinational, with no clock, reset or handshake. The result follows the operands in the same cycle.

The work is split into two stages, each visible in the netlist. The first stage forms the carry-less product of the two operands. It has 2k-1 coefficients s0..s(2k-2). The second stage folds every coefficient at or above alpha^k back into the k low bits. It uses the residues of alpha^i mod P, and these are computed at elaboration time from the polynomial parameter. Each output bit is therefore a fixed XOR of product coefficients.

The default field is k = 4 with P(x) = x^4 + x^3 + 1. Any degree-k irreducible polynomial may be supplied as a (k+1)-bit parameter whose top and bottom bits are set.

Top module: `gfm_mastrovito`

## Requirements
- R1: For the default field (k = 4, P given as 5'b11001), z_o equals a_i·b_i mod P for all 256 operand pairs. Operand and result bit i is the coefficient of alpha^i.
- R2: The unreduced product has 2k-1 coefficients. Coefficient n is the XOR, over all i+j = n, of a_i AND b_j.
- R3: When every product coefficient of degree k or more is zero, z_o equals the low k product coefficients without change. For example, 4'h3·4'h5 gives 4'hF.
- R4: For the default field, the outputs are z0 = s0^s4^s5^s6, z1 = s1^s5^s6, z2 = s2^s6 and z3 = s3^s4^s5^s6.
- R5: A zero operand on either side gives a zero result.
- R6: An operand equal to the unit element (only bit 0 set) returns the other operand unchanged.
- R7: The field is set by the parameters alone. With k = 8 and P given as 9'h11B, 8'h57·8'h83 = 8'hC1 and 8'h57·8'h13 = 8'hFE, and random pairs agree with a bit-serial reference.
- R8: Multiplication is commutative: a·b = b·a for every pair.
- R9: Multiplication distributes over XOR: a·(b^c) = a·b ^ a·c.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | K | First operand, polynomial basis, bit i = coefficient of alpha^i |
| b_i | input | K | Second operand, same encoding |
| z_o | output | K | Reduced product a_i·b_i mod P, same encoding |

## Verification
The default field is swept over all operand pairs against a bit-serial shift-and-add model. This separates a wrong fold column from a wrong partial-product row, because each one corrupts a different subset of pairs. A short vector table pins down single powers of alpha (alpha·alpha^3, alpha^2·alpha^3, alpha^3·alpha^3), which isolate each high coefficient's residue one at a time. Low-degree pairs that need no fold expose the product stage alone. The commutativity and distributivity checks, drawn from the same sweep, catch an asymmetric wiring error that a single reference comparison could also miss. A second instance with an 8-bit field and random operands confirms that the residues really follow the polynomial parameter.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

  localparam int unsigned GFM_MAXW = 64;

  typedef logic [GFM_MAXW-1:0] gfm_word_t;

  // Residue of alpha^pw modulo poly, as a k-bit vector in the low bits.
  function automatic gfm_word_t gfm_residue(input gfm_word_t poly,
                                            input int unsigned k,
                                            input int unsigned pw);
    gfm_word_t r;
    r    = '0;
    r[0] = 1'b1;
    for (int unsigned n = 0; n < pw; n++) begin
      r = r << 1;
      if (r[k]) r = r ^ poly;
    end
    return r;
  endfunction

  // Fold column for output bit j: bit (i-k) set when alpha^i mod P has bit j.
  function automatic gfm_word_t gfm_fold_column(input gfm_word_t poly,
                                                input int unsigned k,
                                                input int unsigned j);
    gfm_word_t col;
    gfm_word_t res;
    col = '0;
    for (int unsigned i = k; i <= 2 * k - 2; i++) begin
      res = gfm_residue(poly, k, i);
      col[i - k] = res[j];
    end
    return col;
  endfunction

endpackage

// File: rtl/gfm_clmul.sv
module gfm_clmul #(
  parameter int unsigned K = 4,
  localparam int unsigned PW = 2 * K - 1
) (
  input  logic [K-1:0]  a_i,
  input  logic [K-1:0]  b_i,
  output logic [PW-1:0] s_o
);

  logic [PW-1:0] row [K];

  for (genvar i = 0; i < K; i++) begin : g_row
    assign row[i] = {{(K-1){1'b0}}, (a_i & {K{b_i[i]}})} << i;
  end

  always_comb begin
    s_o = '0;
    for (int i = 0; i < K; i++) s_o = s_o ^ row[i];
  end

endmodule

// File: rtl/gfm_reduce.sv
module gfm_reduce
  import gfm_pkg::*;
#(
  parameter int unsigned K = 4,
  parameter logic [K:0]  POLY = 5'b11001,
  localparam int unsigned PW = 2 * K - 1,
  localparam int unsigned NHI = K - 1
) (
  input  logic [PW-1:0] s_i,
  output logic [K-1:0]  z_o
);

  logic [NHI-1:0] s_hi;
  assign s_hi = s_i[PW-1:K];

  for (genvar j = 0; j < K; j++) begin : g_col
    localparam gfm_word_t COLW = gfm_fold_column(gfm_word_t'(POLY), K, j);
    localparam logic [NHI-1:0] COL = COLW[NHI-1:0];
    assign z_o[j] = s_i[j] ^ (^(s_hi & COL));
  end

endmodule

// File: rtl/gfm_mastrovito.sv
module gfm_mastrovito #(
  parameter int unsigned K = 4,
  parameter logic [K:0]  POLY = 5'b11001,
  localparam int unsigned PW = 2 * K - 1
) (
  input  logic [K-1:0] a_i,
  input  logic [K-1:0] b_i,
  output logic [K-1:0] z_o
);

  logic [PW-1:0] prod_s;
  logic          hi_any;

  gfm_clmul #(.K(K)) u_clmul (
    .a_i (a_i),
    .b_i (b_i),
    .s_o (prod_s)
  );

  assign hi_any = |prod_s[PW-1:K];

  gfm_reduce #(.K(K), .POLY(POLY)) u_reduce (
    .s_i (prod_s),
    .z_o (z_o)
  );

endmodule

// File: rtl/gfm_mastrovito_chk.sv
module gfm_mastrovito_chk #(
  parameter int unsigned K = 4,
  parameter logic [K:0]  POLY = 5'b11001,
  localparam int unsigned PW = 2 * K - 1
) (
  input logic [K-1:0]  a,
  input logic [K-1:0]  b,
  input logic [PW-1:0] s,
  input logic          hi_any,
  input logic [K-1:0]  z
);

  localparam logic [K-1:0] UNIT = K'(1);

  always_comb begin
    if (!$isunknown({a, b, s, z, hi_any})) begin
      if (a == '0 || b == '0)
        AST_ZERO_RESULT: assert (z == '0); // R5
      if (a == '0)
        AST_ZERO_PRODUCT: assert (s == '0); // R2
      if (a == UNIT)
        AST_UNIT_LEFT: assert (z == b); // R6
      if (b == UNIT)
        AST_UNIT_RIGHT: assert (z == a); // R6
      if (!hi_any)
        AST_NO_FOLD: assert (z == s[K-1:0]); // R3
    end
  end

  if (K == 4 && POLY == 5'b11001) begin : g_default_fold
    always_comb begin
      if (!$isunknown({s, z}))
        AST_FOLD_EQUATIONS: assert (z == {s[3] ^ s[4] ^ s[5] ^ s[6],
                                           s[2] ^ s[6],
                                           s[1] ^ s[5] ^ s[6],
                                           s[0] ^ s[4] ^ s[5] ^ s[6]}); // R4
    end
  end

endmodule

bind gfm_mastrovito gfm_mastrovito_chk #(.K(K), .POLY(POLY)) u_chk (
  .a      (a_i),
  .b      (b_i),
  .s      (prod_s),
  .hi_any (hi_any),
  .z      (z_o)
);

// File: tb/test_gfm_mastrovito.sv
module test_gfm_mastrovito;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [3:0] a4 = '0, b4 = '0;
  logic [3:0] z4;
  logic [7:0] a8 = '0, b8 = '0;
  logic [7:0] z8;

  gfm_mastrovito i_gfm_mastrovito (.a_i(a4), .b_i(b4), .z_o(z4));

  gfm_mastrovito #(.K(8), .POLY(9'h11B)) i_gfm_mastrovito8 (
    .a_i(a8), .b_i(b8), .z_o(z8));

  // Bit-serial model: Horner over y, most significant bit first.
  function automatic logic [7:0] ref_mul(input logic [7:0] x, input logic [7:0] y,
                                         input int k, input logic [8:0] p);
    logic [8:0] r;
    r = '0;
    for (int n = k - 1; n >= 0; n--) begin
      r = r << 1;
      if (r[k]) r = r ^ p;
      if (y[n]) r = r ^ {1'b0, x};
    end
    return r[7:0];
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive4(input logic [3:0] a, input logic [3:0] b);
    @(posedge clk);
    a4 = a;
    b4 = b;
    @(negedge clk);
  endtask

  task automatic drive8(input logic [7:0] a, input logic [7:0] b);
    @(posedge clk);
    a8 = a;
    b8 = b;
    @(negedge clk);
  endtask

  // {a, b, expected} for the default field
  localparam logic [11:0] VEC [9] = '{
    {4'h2, 4'h8, 4'h9},   // alpha^4
    {4'h4, 4'h8, 4'hB},   // alpha^5
    {4'h8, 4'h8, 4'hF},   // alpha^6
    {4'h1, 4'h7, 4'h7},
    {4'h0, 4'hF, 4'h0},
    {4'h3, 4'h3, 4'h5},
    {4'hF, 4'hF, 4'h3},
    {4'h6, 4'h5, 4'h7},
    {4'h3, 4'h5, 4'hF}
  };

  logic [3:0] ztab [16][16];

  task automatic finish_up;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    logic [7:0] ra, rb, zab;

    // Idle operands: zero in gives zero out (R5)
    @(negedge clk);
    check("R5 idle zero", {4'h0, z4}, 8'h00);

    // Vector table: R1 and R4 (single high powers of alpha)
    for (int v = 0; v < 9; v++) begin
      drive4(VEC[v][11:8], VEC[v][7:4]);
      check($sformatf("R1 R4 table %0d", v), {4'h0, z4}, {4'h0, VEC[v][3:0]});
    end

    // No fold needed: low product passes unchanged (R2 R3)
    drive4(4'h3, 4'h5);
    check("R2 R3 no fold 3*5", {4'h0, z4}, 8'h0F);
    drive4(4'h2, 4'h4);
    check("R2 R3 no fold 2*4", {4'h0, z4}, 8'h08);

    // Exhaustive sweep against the reference (R1), zero/unit (R5 R6)
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        drive4(4'(a), 4'(b));
        ztab[a][b] = z4;
        check($sformatf("R1 %h*%h", a, b), {4'h0, z4},
              ref_mul(8'(a), 8'(b), 4, 9'h019));
        if (a == 0 || b == 0) check("R5 zero operand", {4'h0, z4}, 8'h00);
        if (a == 1) check("R6 unit left", {4'h0, z4}, 8'(b));
        if (b == 1) check("R6 unit right", {4'h0, z4}, 8'(a));
      end
    end

    // Commutativity (R8) and distributivity (R9) from measured outputs
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        check($sformatf("R8 %h*%h", a, b), {4'h0, ztab[a][b]}, {4'h0, ztab[b][a]});
        for (int c = 0; c < 16; c += 5) begin
          check($sformatf("R9 %h*(%h^%h)", a, b, c), {4'h0, ztab[a][b ^ c]},
                {4'h0, ztab[a][b] ^ ztab[a][c]});
        end
      end
    end

    // Second field (R7)
    drive8(8'h57, 8'h83);
    check("R7 57*83", z8, 8'hC1);
    drive8(8'h57, 8'h13);
    check("R7 57*13", z8, 8'hFE);
    drive8(8'h01, 8'hA5);
    check("R6 R7 unit k8", z8, 8'hA5);
    for (int n = 0; n < 300; n++) begin
      ra = 8'($urandom);
      rb = 8'($urandom);
      drive8(ra, rb);
      zab = z8;
      check($sformatf("R7 %h*%h", ra, rb), zab, ref_mul(ra, rb, 8, 9'h11B));
      drive8(rb, ra);
      check($sformatf("R8 k8 %h*%h", ra, rb), z8, zab);
    end

    finish_up();
  end

endmodule